// File: doc/BRIEF.md
# Receive Decimation Chain

This block lowers the sample rate of a complex baseband stream. The I and Q samples come in together under one valid strobe. Both lanes pass through the same set of fixed-coefficient decimating filters, and the rate-reduced pair leaves under its own valid strobe. The first section of the chain has two forms. One is a single divide-by-five filter. The other is a cascade of two FIR stages and a third half-band filter, which reduces the rate by 2, 4 or 8. After the first section come two half-band stages, and each of them can be bypassed. The last half-band has four coefficient sets: a high-rejection or a low-power shape, each with a wide or a narrow passband.

The configuration pins are static. The chain copies them into its own register during reset, and afterwards only in cycles where no input sample is presented. When a change is captured, every delay line, every phase counter and every pending output is cleared. Each stage rounds its result half-up and saturates it to the sample width before passing it on.

Top module: `ddc_decim_chain`

## Requirements
- R1: While reset is asserted, and after it until the first result, out_valid is 0 and out_i and out_q are 0.
- R2: With cfg_front_div5=1, the front section is one stage that decimates by 5. Its taps, newest sample first, are 1,2,2,2,1 and its result is shifted right by 3.
- R3: With cfg_front_div5=0, the front section is three stages. The first has taps 1,3,3,1 with shift 3 and is bypassed by cfg_fir2_bypass. The second has taps -1,2,7,7,2,-1 with shift 4 and is bypassed by cfg_fir1_bypass. The third always decimates, with taps -1,0,9,16,9,0,-1 and shift 5. The total factor of the section is therefore 2, 4 or 8.
- R4: The middle half-band has taps 3,0,-25,0,150,256,150,0,-25,0,3 with shift 9. It either decimates by 2 or, with cfg_hb2_bypass=1, passes samples through unchanged.
- R5: The final half-band has shift 9 and can be bypassed with cfg_hb1_bypass. The pair {cfg_hb1_lowpower, cfg_hb1_wide} picks its 11 symmetric taps: 00 = 3,0,-25,0,150,256,…; 01 = 6,0,-34,0,156,256,…; 10 = 0,0,-16,0,144,256,…; 11 = 0,0,-32,0,160,256,….
- R6: A decimating stage with factor F produces one result on each F-th accepted sample, counted from reset or from a flush. The result uses that sample and the older ones in the stage, with zeros in place of samples never received. A bypassed stage forwards every sample after one register.
- R7: At every stage boundary a result is rounded by adding 2^(shift-1) and shifting right arithmetically. It is then saturated to the signed range of DW bits.
- R8: The Q lane applies exactly the same filtering as the I lane to its own data.
- R9: The configuration is captured only in reset or in cycles with in_valid=0. Pin changes made while samples flow have no effect.
- R10: A captured configuration change clears all delay lines, phase counters and pending outputs. out_valid is 0 in the following cycle, and later results equal those of a chain fresh out of reset.
- R11: out_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase input sample, signed |
| in_q | input | DW | Quadrature input sample, signed |
| cfg_front_div5 | input | 1 | 1 selects the divide-by-five front, 0 the FIR/half-band cascade |
| cfg_fir2_bypass | input | 1 | Bypass the first cascade FIR |
| cfg_fir1_bypass | input | 1 | Bypass the second cascade FIR |
| cfg_hb2_bypass | input | 1 | Bypass the middle half-band |
| cfg_hb1_bypass | input | 1 | Bypass the final half-band |
| cfg_hb1_lowpower | input | 1 | Final half-band low-power shape |
| cfg_hb1_wide | input | 1 | Final half-band wide passband |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | In-phase output sample, signed |
| out_q | output | DW | Quadrature output sample, signed |

## Verification
The assertions check four rules on every cycle. A stage emits only in the cycle after it accepted a sample. A decimating stage never emits twice in a row. The configuration register does not move while samples are arriving. A flush is followed by a quiet output. The numeric results can only be shown by the bench scenarios, because they depend on a whole history of samples: the taps, the phase at which each stage emits, half-up rounding and clipping at the rails. The same holds for the rule that a flush leaves no stale state behind, which the bench shows by replaying a fresh-chain model after a change made mid-history.

// File: rtl/ddc_dec_pkg.sv
`timescale 1ns/1ps
package ddc_dec_pkg;

  typedef enum logic [2:0] {
    ST_DIV5, ST_FIRA, ST_FIRB, ST_HB3, ST_HB2, ST_HB1
  } stage_e;

  typedef struct packed {
    logic front_div5;
    logic fira_byp;
    logic firb_byp;
    logic hb2_byp;
    logic hb1_byp;
    logic hb1_lowpwr;
    logic hb1_wide;
  } chain_cfg_t;

  function automatic int stage_taps(stage_e st);
    case (st)
      ST_DIV5: return 5;
      ST_FIRA: return 4;
      ST_FIRB: return 6;
      ST_HB3:  return 7;
      default: return 11;
    endcase
  endfunction

  function automatic int stage_shift(stage_e st);
    case (st)
      ST_DIV5: return 3;
      ST_FIRA: return 3;
      ST_FIRB: return 4;
      ST_HB3:  return 5;
      default: return 9;
    endcase
  endfunction

  // Tap k, k = 0 is the newest sample. The 11-tap half-bands are symmetric,
  // so only the distance from the outer edge matters.
  function automatic int tap_coef(stage_e st, logic [1:0] vsel, int k);
    int m;
    m = (k > 5) ? 10 - k : k;
    case (st)
      ST_DIV5: return (k == 0 || k == 4) ? 1 : 2;
      ST_FIRA: return (k == 0 || k == 3) ? 1 : 3;
      ST_FIRB: begin
        if (k == 0 || k == 5) return -1;
        if (k == 1 || k == 4) return 2;
        return 7;
      end
      ST_HB3: begin
        if (k == 0 || k == 6) return -1;
        if (k == 1 || k == 5) return 0;
        if (k == 2 || k == 4) return 9;
        return 16;
      end
      ST_HB2: begin
        case (m)
          0: return 3;
          2: return -25;
          4: return 150;
          5: return 256;
          default: return 0;
        endcase
      end
      default: begin
        if (m == 5) return 256;
        if (m == 1 || m == 3) return 0;
        case (vsel)
          2'b00: return (m == 0) ? 3 : (m == 2) ? -25 : 150;
          2'b01: return (m == 0) ? 6 : (m == 2) ? -34 : 156;
          2'b10: return (m == 0) ? 0 : (m == 2) ? -16 : 144;
          default: return (m == 0) ? 0 : (m == 2) ? -32 : 160;
        endcase
      end
    endcase
  endfunction

  // Round half-up by the stage shift, then clip to a signed dw-bit range.
  function automatic longint rnd_sat(longint acc, int sh, int dw);
    longint r;
    longint hi;
    longint lo;
    r  = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (dw - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction

endpackage

// File: rtl/ddc_dec_cfg.sv
`timescale 1ns/1ps
module ddc_dec_cfg
  import ddc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  chain_cfg_t cfg_in,
  output chain_cfg_t cfg_q,
  output logic       flush
);

  // A differing setting is taken only in an idle cycle; taking it flushes.
  assign flush = rst_n && !in_valid && (cfg_in != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= cfg_in;
    else if (flush) cfg_q <= cfg_in;
  end

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $stable(cfg_q));

endmodule

// File: rtl/ddc_dec_stage.sv
`timescale 1ns/1ps
module ddc_dec_stage
  import ddc_dec_pkg::*;
#(
  parameter stage_e STAGE  = ST_HB3,
  parameter int     DW     = 16,
  parameter int     FACTOR = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 bypass,
  input  logic [1:0]           vsel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int NTAP  = stage_taps(STAGE);
  localparam int SHIFT = stage_shift(STAGE);
  localparam int PW    = $clog2(FACTOR);

  logic [PW-1:0] phase;
  logic          take;   // sample enters the delay line
  logic          emit;   // this sample completes a decimation period

  assign take = in_valid && !bypass;
  assign emit = take && (phase == PW'(FACTOR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || flush)  phase <= '0;
    else if (take)        phase <= (phase == PW'(FACTOR - 1)) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) out_valid <= 1'b0;
    else if (bypass)     out_valid <= in_valid;
    else                 out_valid <= emit;
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [DW-1:0] din;
    logic signed [DW-1:0] line [NTAP-1];
    logic signed [DW-1:0] win  [NTAP];
    logic signed [DW-1:0] y;
    logic signed [DW-1:0] dout;
    longint               acc;

    assign din = (l == 0) ? in_i : in_q;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        for (int k = 0; k < NTAP - 1; k++) line[k] <= '0;
      end else if (take) begin
        line[0] <= din;
        for (int k = 1; k < NTAP - 1; k++) line[k] <= line[k-1];
      end
    end

    always_comb begin
      win[0] = din;
      for (int k = 1; k < NTAP; k++) win[k] = line[k-1];
      acc = 0;
      for (int k = 0; k < NTAP; k++) begin
        // zero taps (odd half-band taps) contribute no product
        if (tap_coef(STAGE, vsel, k) != 0)
          acc = acc + longint'(tap_coef(STAGE, vsel, k)) * longint'(win[k]);
      end
      y = DW'(rnd_sat(acc, SHIFT, DW));
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush)       dout <= '0;
      else if (bypass) begin
        if (in_valid)            dout <= din;
      end else if (emit)         dout <= y;
    end

    if (l == 0) begin : g_oi
      assign out_i = dout;
    end else begin : g_oq
      assign out_q = dout;
    end
  end

  a_r6_out_after_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && out_valid) |=> !out_valid);

endmodule

// File: rtl/ddc_decim_chain.sv
`timescale 1ns/1ps
module ddc_decim_chain
  import ddc_dec_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 cfg_front_div5,
  input  logic                 cfg_fir2_bypass,
  input  logic                 cfg_fir1_bypass,
  input  logic                 cfg_hb2_bypass,
  input  logic                 cfg_hb1_bypass,
  input  logic                 cfg_hb1_lowpower,
  input  logic                 cfg_hb1_wide,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  chain_cfg_t cfg_pins;
  chain_cfg_t cfg_q;
  logic       cfg_flush;

  assign cfg_pins = {cfg_front_div5, cfg_fir2_bypass, cfg_fir1_bypass,
                     cfg_hb2_bypass, cfg_hb1_bypass, cfg_hb1_lowpower, cfg_hb1_wide};

  ddc_dec_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cfg_in(cfg_pins), .cfg_q(cfg_q), .flush(cfg_flush)
  );

  logic d5_in_v, cas_in_v;
  assign d5_in_v  = in_valid &&  cfg_q.front_div5;
  assign cas_in_v = in_valid && !cfg_q.front_div5;

  logic d5_v, fa_v, fb_v, h3_v, fr_v, h2_v;
  logic signed [DW-1:0] d5_i, d5_q, fa_i, fa_q, fb_i, fb_q, h3_i, h3_q;
  logic signed [DW-1:0] fr_i, fr_q, h2_i, h2_q;

  ddc_dec_stage #(.STAGE(ST_DIV5), .DW(DW), .FACTOR(5)) u_div5 (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(1'b0), .vsel(2'b00),
    .in_valid(d5_in_v), .in_i(in_i), .in_q(in_q),
    .out_valid(d5_v), .out_i(d5_i), .out_q(d5_q)
  );

  ddc_dec_stage #(.STAGE(ST_FIRA), .DW(DW), .FACTOR(2)) u_fira (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(cfg_q.fira_byp), .vsel(2'b00),
    .in_valid(cas_in_v), .in_i(in_i), .in_q(in_q),
    .out_valid(fa_v), .out_i(fa_i), .out_q(fa_q)
  );

  ddc_dec_stage #(.STAGE(ST_FIRB), .DW(DW), .FACTOR(2)) u_firb (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(cfg_q.firb_byp), .vsel(2'b00),
    .in_valid(fa_v), .in_i(fa_i), .in_q(fa_q),
    .out_valid(fb_v), .out_i(fb_i), .out_q(fb_q)
  );

  ddc_dec_stage #(.STAGE(ST_HB3), .DW(DW), .FACTOR(2)) u_hb3 (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(1'b0), .vsel(2'b00),
    .in_valid(fb_v), .in_i(fb_i), .in_q(fb_q),
    .out_valid(h3_v), .out_i(h3_i), .out_q(h3_q)
  );

  // Front-section select; the unused path receives no samples.
  assign fr_v = cfg_q.front_div5 ? d5_v : h3_v;
  assign fr_i = cfg_q.front_div5 ? d5_i : h3_i;
  assign fr_q = cfg_q.front_div5 ? d5_q : h3_q;

  ddc_dec_stage #(.STAGE(ST_HB2), .DW(DW), .FACTOR(2)) u_hb2 (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(cfg_q.hb2_byp), .vsel(2'b00),
    .in_valid(fr_v), .in_i(fr_i), .in_q(fr_q),
    .out_valid(h2_v), .out_i(h2_i), .out_q(h2_q)
  );

  ddc_dec_stage #(.STAGE(ST_HB1), .DW(DW), .FACTOR(2)) u_hb1 (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .bypass(cfg_q.hb1_byp),
    .vsel({cfg_q.hb1_lowpwr, cfg_q.hb1_wide}),
    .in_valid(h2_v), .in_i(h2_i), .in_q(h2_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flush |=> !out_valid);

  a_r11_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: tb/ddc_decim_chain_test.sv
`timescale 1ns/1ps
module ddc_decim_chain_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic c_d5 = 1'b0, c_fab = 1'b1, c_fbb = 1'b1, c_h2b = 1'b1, c_h1b = 1'b1, c_lp = 1'b0, c_wd = 1'b0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int checks = 0, errors = 0, b2b = 0;
  bit prev_ov = 1'b0;
  int si[$], sq[$], gi[$], gq[$];

  always #2.5 clk = ~clk;

  ddc_decim_chain #(.DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_front_div5(c_d5), .cfg_fir2_bypass(c_fab), .cfg_fir1_bypass(c_fbb),
    .cfg_hb2_bypass(c_h2b), .cfg_hb1_bypass(c_h1b), .cfg_hb1_lowpower(c_lp),
    .cfg_hb1_wide(c_wd), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      gi.push_back(int'(out_i));
      gq.push_back(int'(out_q));
    end
    if (rst_n && out_valid && prev_ov) b2b++;
    prev_ov = rst_n && out_valid;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void get_taps(int st, int v, output int t[$]);
    case (st)
      0: t = '{1, 2, 2, 2, 1};
      1: t = '{1, 3, 3, 1};
      2: t = '{-1, 2, 7, 7, 2, -1};
      3: t = '{-1, 0, 9, 16, 9, 0, -1};
      4: t = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};
      default: case (v)
        0: t = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};
        1: t = '{6, 0, -34, 0, 156, 256, 156, 0, -34, 0, 6};
        2: t = '{0, 0, -16, 0, 144, 256, 144, 0, -16, 0, 0};
        default: t = '{0, 0, -32, 0, 160, 256, 160, 0, -32, 0, 0};
      endcase
    endcase
  endfunction

  // floor(a / 2^sh + 1/2), clipped to 16-bit signed
  function automatic int rnd_clip(longint a, int sh);
    longint d, q, r;
    d = longint'(1) << sh;
    q = a / d;
    r = a - q * d;
    if (r < 0) begin q = q - 1; r = r + d; end
    if (2 * r >= d) q = q + 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  function automatic void stage_model(int st, int v, int fac, bit byp, ref int q[$]);
    int t[$];
    int o[$];
    int sum, sh;
    longint acc;
    if (byp) return;
    get_taps(st, v, t);
    sum = 0;
    foreach (t[k]) sum += t[k];
    sh = $clog2(sum);
    for (int n = 0; n < q.size(); n++) begin
      acc = 0;
      foreach (t[k]) if (n - k >= 0) acc += longint'(t[k]) * longint'(q[n-k]);
      if ((n + 1) % fac == 0) o.push_back(rnd_clip(acc, sh));
    end
    q = o;
  endfunction

  function automatic void chain_model(ref int q[$]);
    if (c_d5) stage_model(0, 0, 5, 1'b0, q);
    else begin
      stage_model(1, 0, 2, c_fab, q);
      stage_model(2, 0, 2, c_fbb, q);
      stage_model(3, 0, 2, 1'b0, q);
    end
    stage_model(4, 0, 2, c_h2b, q);
    stage_model(5, {c_lp, c_wd}, 2, c_h1b, q);
  endfunction

  task automatic cmpq(string tag, int g[$], int e[$]);
    bit ok = 1'b1;
    int a = 0, x = 0;
    for (int i = 0; i < g.size() && i < e.size(); i++)
      if (ok && g[i] != e[i]) begin ok = 1'b0; a = g[i]; x = e[i]; end
    chk(ok && g.size() == e.size(), tag, "sample stream", a, x);
  endtask

  task automatic setpins(bit d5, bit fab, bit fbb, bit h2b, bit h1b, bit lp, bit wd);
    c_d5 = d5; c_fab = fab; c_fbb = fbb; c_h2b = h2b; c_h1b = h1b; c_lp = lp; c_wd = wd;
  endtask

  task automatic feed(int n, int mode, bit wiggle);
    int xi, xq;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mode == 2) xi = (i % 6 == 1) ? -32768 : 32767;
      else if (mode == 1) xi = int'($urandom_range(0, 4000)) - 2000;
      else xi = int'($urandom_range(0, 65535)) - 32768;
      xq = int'($urandom_range(0, 65535)) - 32768;
      in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
      si.push_back(xi); sq.push_back(xq);
      if (wiggle && i == n / 2) begin c_d5 = !c_d5; c_h1b = !c_h1b; c_wd = !c_wd; end
      if (wiggle && i == n - 1) begin c_d5 = !c_d5; c_h1b = !c_h1b; c_wd = !c_wd; end
      if (!wiggle && $urandom_range(0, 2) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic run(bit d5, bit fab, bit fbb, bit h2b, bit h1b, bit lp, bit wd,
                     int n, int mode, bit wiggle, bit direct, string tag);
    int ei[$], eq[$];
    if (!direct) begin
      setpins(d5, fab, fbb, h2b, h1b, lp, !wd);
      repeat (3) @(negedge clk);
    end
    setpins(d5, fab, fbb, h2b, h1b, lp, wd);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after config change", out_valid, 0);
    repeat (2) @(negedge clk);
    gi.delete(); gq.delete(); si.delete(); sq.delete();
    feed(n, mode, wiggle);
    repeat (30) @(negedge clk);
    ei = si; eq = sq;
    chain_model(ei);
    chain_model(eq);
    chk(gi.size() == ei.size(), "R6", "output count", gi.size(), ei.size());
    cmpq(tag, gi, ei);
    cmpq("R8", gq, eq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit hit;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_i == 0 && out_q == 0, "R1", "data after reset", out_i, 0);

    // R2: divide-by-five front, later stages bypassed
    run(1, 1, 1, 1, 1, 0, 0, 60, 0, 0, 0, "R2");
    // R3: cascade totals 2, 4, 8
    run(0, 1, 1, 1, 1, 0, 0, 40, 0, 0, 0, "R3");
    run(0, 0, 1, 1, 1, 0, 0, 64, 1, 0, 0, "R3");
    run(0, 0, 0, 1, 1, 0, 0, 96, 0, 0, 0, "R3");
    // R4: middle half-band active
    run(0, 1, 0, 0, 1, 0, 0, 80, 0, 0, 0, "R4");
    // R5: four final half-band shapes
    for (int v = 0; v < 4; v++)
      run(1, 1, 1, 1, 0, v[1], v[0], 100, 0, 0, 0, "R5");
    // R7: overshoot pattern must clip at the positive rail
    run(0, 1, 1, 1, 1, 0, 0, 48, 2, 0, 0, "R7");
    hit = 1'b0;
    foreach (gi[k]) if (gi[k] == 32767) hit = 1'b1;
    chk(hit, "R7", "saturated sample seen", hit, 1);
    // R9: pin changes during a gapless burst are ignored
    run(0, 1, 1, 1, 0, 1, 0, 60, 0, 1, 0, "R9");
    // R10: leave partial state, change config directly, expect fresh behaviour
    run(0, 1, 1, 0, 1, 0, 0, 9, 0, 0, 0, "R10");
    run(0, 1, 1, 0, 0, 0, 1, 80, 0, 0, 1, "R10");
    // R11: never two results back to back
    chk(b2b == 0, "R11", "back-to-back out_valid", b2b, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule